// File: doc/BRIEF.md
# Interface Pattern Checker

This block tests a byte-wide double-data-rate input link for setup and hold faults. The bench or upstream capture logic hands it one received byte per clock cycle, each tagged with the data-clock edge it was captured on. The block holds an eight-word reference pattern. After a rising frame marker, it compares each byte with the word expected at that position and gathers the result.

A bit that differs in any compare sets the matching bit of a sticky result register. Any difference also sets a summary alarm. After the first marker the expected-word index free-runs through the pattern, one step per byte. A later marker edge pulls the index back to word 0. Software reaches the reference words, the test enable, the results and the alarm through a small register port, and clears the results by writing zero. While the test is enabled, a mute output tells the converter outputs to stay silent.

Top module: `iface_pat_chk`

## Requirements
- R1: After reset, reference words 0 to 7 read back as 0x7A, 0xB6, 0xEA, 0x45, 0x1A, 0x16, 0xAA, 0xC6 at addresses 0 to 7. The result register (address 9), the alarm (address 10, bit 0) and the control register (address 8, bit 0 = test enable) read 0.
- R2: A write to addresses 0 to 7 replaces that reference word. The new value reads back, and later compares use it.
- R3: With the test enabled, a valid byte captured on a rising edge (rise flag 1) with the frame marker high is a marker edge if the marker was low on the previous rising-edge byte. That byte is compared with word 0, and the following valid bytes are compared with words 1, 2 and on.
- R4: After a marker edge the index wraps from 7 to 0 and keeps cycling without further markers.
- R5: A frame marker on a falling-edge byte (rise flag 0) is ignored. It neither aligns the index nor counts as the previous marker level.
- R6: After the test is enabled and before the first marker edge, no compares are made and the results stay zero.
- R7: Every compare ORs the bitwise difference of received and expected bytes into the result register. For example, 0x7B against 0x7A sets bit 0.
- R8: Any compare with a difference sets the alarm.
- R9: Writing 0x00 to the result register and 0 to the alarm clears them, and the next mismatch sets them again. A mismatch in the same cycle as the write takes precedence.
- R10: A marker edge that arrives while the index is not 0 realigns: that byte is compared with word 0 and the next byte with word 1.
- R11: The mute output equals the test enable. Clearing the enable stops compares and drops alignment, so a new marker edge is needed after re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte-slot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_vld_i | input | 1 | A received byte is present this cycle |
| slot_rise_i | input | 1 | 1: byte captured on the rising data-clock edge; 0: falling edge |
| slot_byte_i | input | WORD_W | Received byte |
| frame_i | input | 1 | Frame marker as received with the byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | WORD_W | Register write data |
| reg_rdata_o | output | WORD_W | Register read data (combinational on the address) |
| mute_o | output | 1 | Mutes the converter outputs while the test runs |

## Verification
The bench builds the block with its default parameters: eight-bit words and an eight-word pattern. With these, a full index wrap takes only eight bytes, so long random streams pass through many wraps, realignments, ignored falling-edge markers and clear-then-reset sequences. At eight bits the whole result register is compared against the model, so every bit position and the reset-default pattern are visible to the checks.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  function automatic logic [7:0] pat_default(int i);
    case (i)
      0: return 8'h7A;
      1: return 8'hB6;
      2: return 8'hEA;
      3: return 8'h45;
      4: return 8'h1A;
      5: return 8'h16;
      6: return 8'hAA;
      7: return 8'hC6;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ipc_pattern_regs.sv
module ipc_pattern_regs #(
  parameter int WORD_W  = 8,
  parameter int N_WORDS = 8,
  parameter int IDX_W   = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  cmp_idx_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [WORD_W-1:0] exp_o
);
  logic [WORD_W-1:0] word_q [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q[g] <= WORD_W'(ipc_pkg::pat_default(g));
      else if (wr_i && (wr_idx_i == IDX_W'(g)))      word_q[g] <= wdata_i;
    end
  end

  assign rd_word_o = word_q[rd_idx_i];
  assign exp_o     = word_q[cmp_idx_i];
endmodule

// File: rtl/ipc_align.sv
module ipc_align #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic             rise_i,
  input  logic             frame_i,
  output logic             edge_o,
  output logic             aligned_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cmp_vld_o,
  output logic [IDX_W-1:0] cmp_idx_o
);
  logic frame_q;

  // marker level only tracked on rising-edge bytes
  assign edge_o = vld_i && rise_i && frame_i && !frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= 1'b0;
      aligned_o <= 1'b0;
      idx_o     <= '0;
    end else begin
      if (vld_i && rise_i) frame_q <= frame_i;
      if (!en_i) begin
        aligned_o <= 1'b0;
        idx_o     <= '0;
      end else if (vld_i) begin
        if (edge_o) begin
          aligned_o <= 1'b1;
          idx_o     <= IDX_W'(1);
        end else if (aligned_o) begin
          idx_o     <= idx_o + IDX_W'(1);
        end
      end
    end
  end

  assign cmp_vld_o = en_i && vld_i && (edge_o || aligned_o);
  assign cmp_idx_o = edge_o ? '0 : idx_o;
endmodule

// File: rtl/ipc_err_acc.sv
module ipc_err_acc #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_vld_i,
  input  logic [WORD_W-1:0] rx_i,
  input  logic [WORD_W-1:0] exp_i,
  input  logic              res_wr_i,
  input  logic              alarm_wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] res_o,
  output logic              alarm_o
);
  logic [WORD_W-1:0] diff;

  assign diff = cmp_vld_i ? (rx_i ^ exp_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      alarm_o <= 1'b0;
    end else begin
      res_o   <= (res_wr_i ? wdata_i : res_o) | diff;
      alarm_o <= (alarm_wr_i ? wdata_i[0] : alarm_o) | (|diff);
    end
  end
endmodule

// File: rtl/iface_pat_chk.sv
module iface_pat_chk #(
  parameter int WORD_W  = 8,
  parameter int N_WORDS = 8,
  parameter int ADDR_W  = $clog2(N_WORDS + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_vld_i,
  input  logic              slot_rise_i,
  input  logic [WORD_W-1:0] slot_byte_i,
  input  logic              frame_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              mute_o
);
  localparam int IDX_W = $clog2(N_WORDS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(N_WORDS);
  localparam logic [ADDR_W-1:0] RES_A  = ADDR_W'(N_WORDS + 1);
  localparam logic [ADDR_W-1:0] ALM_A  = ADDR_W'(N_WORDS + 2);

  logic              en_q;
  logic              pat_wr, res_wr, alarm_wr;
  logic              align_edge, aligned, cmp_vld;
  logic [IDX_W-1:0]  idx, cmp_idx;
  logic [WORD_W-1:0] exp_word, rd_word, res_q;
  logic              alarm_q;

  assign pat_wr   = reg_wr_i && (reg_addr_i < ADDR_W'(N_WORDS));
  assign res_wr   = reg_wr_i && (reg_addr_i == RES_A);
  assign alarm_wr = reg_wr_i && (reg_addr_i == ALM_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_q <= 1'b0;
    else if (reg_wr_i && (reg_addr_i == CTRL_A))   en_q <= reg_wdata_i[0];
  end

  ipc_pattern_regs #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_pat (
    .clk_i, .rst_ni,
    .wr_i      (pat_wr),
    .wr_idx_i  (reg_addr_i[IDX_W-1:0]),
    .wdata_i   (reg_wdata_i),
    .rd_idx_i  (reg_addr_i[IDX_W-1:0]),
    .cmp_idx_i (cmp_idx),
    .rd_word_o (rd_word),
    .exp_o     (exp_word)
  );

  ipc_align #(.IDX_W(IDX_W)) u_align (
    .clk_i, .rst_ni,
    .en_i      (en_q),
    .vld_i     (slot_vld_i),
    .rise_i    (slot_rise_i),
    .frame_i   (frame_i),
    .edge_o    (align_edge),
    .aligned_o (aligned),
    .idx_o     (idx),
    .cmp_vld_o (cmp_vld),
    .cmp_idx_o (cmp_idx)
  );

  ipc_err_acc #(.WORD_W(WORD_W)) u_acc (
    .clk_i, .rst_ni,
    .cmp_vld_i  (cmp_vld),
    .rx_i       (slot_byte_i),
    .exp_i      (exp_word),
    .res_wr_i   (res_wr),
    .alarm_wr_i (alarm_wr),
    .wdata_i    (reg_wdata_i),
    .res_o      (res_q),
    .alarm_o    (alarm_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < ADDR_W'(N_WORDS)) reg_rdata_o = rd_word;
    else if (reg_addr_i == CTRL_A)     reg_rdata_o[0] = en_q;
    else if (reg_addr_i == RES_A)      reg_rdata_o = res_q;
    else if (reg_addr_i == ALM_A)      reg_rdata_o[0] = alarm_q;
  end

  assign mute_o = en_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int WORD_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic              rise_i,
  input logic              en,
  input logic              align_edge,
  input logic              aligned,
  input logic [IDX_W-1:0]  idx,
  input logic              cmp_vld,
  input logic              res_wr,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] res,
  input logic              alarm
);
  assert_falling_marker_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_i && rise_i) |-> !align_edge);

  assert_edge_realigns_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && align_edge) |=> (aligned && idx == IDX_W'(1)));

  assert_index_cycles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && vld_i && aligned && !align_edge) |=> (idx == $past(idx) + IDX_W'(1)));

  assert_no_cmp_unaligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aligned && !align_edge && !res_wr) |=> $stable(res));

  assert_disable_drops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (!aligned && idx == '0));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_wr && wdata == '0 && !cmp_vld) |=> (res == '0));

  assert_alarm_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(res_wr) && $rose(|res)) |-> alarm);
endmodule

bind iface_pat_chk ipc_checker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vld_i      (slot_vld_i),
  .rise_i     (slot_rise_i),
  .en         (en_q),
  .align_edge (align_edge),
  .aligned    (aligned),
  .idx        (idx),
  .cmp_vld    (cmp_vld),
  .res_wr     (res_wr),
  .wdata      (reg_wdata_i),
  .res        (res_q),
  .alarm      (alarm_q)
);

// File: tb/iface_pat_chk_tb_top.sv
module iface_pat_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CTRL = 4'd8, A_RES = 4'd9, A_ALM = 4'd10;

  logic clk = 0, rst_ni = 0;
  logic vld = 0, rise = 0, frame = 0, wr = 0;
  logic [W-1:0] bytev = 0, wdata = 0, rdata;
  logic [AW-1:0] addr = 0;
  logic mute;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_pat [N];
  logic [W-1:0] m_res = 0;
  logic m_alarm = 0, m_en = 0, m_al = 0, m_fprev = 0;
  int m_idx = 0;
  int s_idx = 0;
  bit ph_rise = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  iface_pat_chk dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .slot_vld_i(vld), .slot_rise_i(rise),
    .slot_byte_i(bytev), .frame_i(frame), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mute_o(mute)
  );

  function automatic logic [W-1:0] def_pat(int i);
    logic [W-1:0] t [N] = '{8'h7A, 8'hB6, 8'hEA, 8'h45, 8'h1A, 8'h16, 8'hAA, 8'hC6};
    return t[i];
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // model step for one clock cycle with the given inputs
  task automatic model(bit v, bit r, bit f, logic [W-1:0] b, bit w, logic [AW-1:0] a, logic [W-1:0] wd);
    logic [W-1:0] diff = 0;
    bit e = v && r && f && !m_fprev;
    if (v && m_en && (e || m_al)) begin
      diff = b ^ m_pat[e ? 0 : m_idx];
    end
    if (!m_en) begin m_al = 0; m_idx = 0; end
    else if (v) begin
      if (e) begin m_al = 1; m_idx = 1; end
      else if (m_al) m_idx = (m_idx + 1) % N;
    end
    if (v && r) m_fprev = f;
    m_res   = ((w && a == A_RES) ? wd : m_res) | diff;
    m_alarm = ((w && a == A_ALM) ? wd[0] : m_alarm) | (|diff);
    if (w && a < N) m_pat[a] = wd;
    if (w && a == A_CTRL) m_en = wd[0];
  endtask

  task automatic cyc(bit v, bit f, logic [W-1:0] b, bit w = 0, logic [AW-1:0] a = 0, logic [W-1:0] wd = 0);
    @(negedge clk);
    vld = v; rise = ph_rise; frame = f; bytev = b; wr = w; addr = a; wdata = wd;
    @(posedge clk);
    model(v, ph_rise, f, b, w, a, wd);
    #1; vld = 0; wr = 0;
    if (v) ph_rise = !ph_rise;
  endtask

  task automatic wreg(logic [AW-1:0] a, logic [W-1:0] d);
    cyc(0, 0, 0, 1, a, d);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  // send one correct stream byte, optionally corrupted
  task automatic send(logic [W-1:0] flip = 0, bit f = 0);
    if (f) s_idx = 0;
    cyc(1, f, m_pat[s_idx] ^ flip);
    s_idx = (s_idx + 1) % N;
  endtask

  task automatic chk_state(string req);
    logic [W-1:0] d;
    rd(A_RES, d); check(req, d, m_res);
    rd(A_ALM, d); check(req, d, {7'b0, m_alarm});
  endtask

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) m_pat[i] = def_pat(i);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;

    // R1 reset state
    for (int i = 0; i < N; i++) begin
      rd(AW'(i), d); check("R1 word default", d, def_pat(i));
    end
    rd(A_CTRL, d); check("R1 ctrl", d, 8'h00);
    chk_state("R1 results/alarm");
    check("R11 mute at reset", {7'b0, mute}, 8'h00);

    // R2 rewrite a word
    wreg(4'd3, 8'h3C);
    rd(4'd3, d); check("R2 readback", d, 8'h3C);

    // R6 enable, garbage without marker
    wreg(A_CTRL, 8'h01);
    check("R11 mute when enabled", {7'b0, mute}, 8'h01);
    for (int i = 0; i < 10; i++) cyc(1, 0, 8'hFF);
    chk_state("R6 no compare before marker");
    check("R6 res zero", m_res, 8'h00);

    // R5 marker on falling slots only
    if (ph_rise) cyc(1, 0, 8'h55);
    for (int i = 0; i < 6; i++) cyc(1, !ph_rise, 8'hA5);
    chk_state("R5 falling marker ignored");

    // R3/R4 align on rising slot then clean pattern, several wraps
    if (!ph_rise) cyc(1, 0, 8'h00);
    send(0, 1);
    for (int i = 0; i < 3 * N + 3; i++) send();
    chk_state("R3/R4 clean stream");
    check("R4 clean res", m_res, 8'h00);

    // R7/R8 single-bit error on word 0 (default 0x7A received as 0x7B)
    while (s_idx != 0) send();
    send(8'h01);
    chk_state("R7 bit0 error");
    check("R7 model bit0", m_res, 8'h01);
    check("R8 alarm", {7'b0, m_alarm}, 8'h01);

    // R2 new word 3 used in compare: clean stream must stay clean on top of prior
    for (int i = 0; i < N; i++) send();
    chk_state("R2 compare uses rewritten word");

    // R9 clear and re-set
    wreg(A_RES, 8'h00); wreg(A_ALM, 8'h00);
    chk_state("R9 cleared");
    check("R9 cleared model", m_res, 8'h00);
    for (int i = 0; i < 5; i++) send();
    send(8'h90);
    chk_state("R9 set again");
    check("R9 set again model", m_res, 8'h90);

    // R10 realign mid cycle (index 4 on rising slot)
    wreg(A_RES, 8'h00); wreg(A_ALM, 8'h00);
    while (!(s_idx == 4 && ph_rise)) send();
    send(0, 1);
    for (int i = 0; i < 2 * N; i++) send();
    chk_state("R10 realign clean");
    check("R10 clean model", m_res, 8'h00);

    // R11 disable stops compares and drops alignment
    wreg(A_CTRL, 8'h00);
    check("R11 mute off", {7'b0, mute}, 8'h00);
    for (int i = 0; i < 9; i++) cyc(1, 0, 8'hFF);
    wreg(A_CTRL, 8'h01);
    for (int i = 0; i < 9; i++) cyc(1, 0, 8'hFF);
    chk_state("R11 no compare after re-enable");

    // random stream
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) wreg(A_RES, 8'h00);
      else if (r < 3) wreg(A_ALM, 8'h00);
      else if (r < 4) wreg(AW'($urandom_range(0, N-1)), 8'($urandom));
      else if (r < 9 && ph_rise && !m_fprev) send(0, 1);
      else if (r < 12 && !ph_rise) cyc(1, 1, m_pat[s_idx]);
      else if (r < 16) send(8'(1 << $urandom_range(0, 7)));
      else send();
      if (ph_rise && frame == 0) ; // marker returns low on next rising slot via send()
      if (k % 64 == 63) chk_state("R3/R7/R8/R9/R10 random");
    end
    chk_state("R4/R7 random end");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule